// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block decides which of four DMA channels gets the bus next. Each channel can be requested in two ways: an external request pin, or a software request bit. An external request is sensed at a programmable polarity and can be masked. A software request ignores the mask. All pending requests go through one priority decision. That decision uses either a fixed order or a rotating order in which the channel just served drops to the bottom.

Once a channel wins, the block raises a hold request toward the host. When hold acknowledge arrives, it drives that channel's acknowledge pin at a programmable polarity. The winner stays latched until the transfer engine signals end of service. If that end is a terminal count or an external end-of-process, the channel's software request is dropped. The channel's mask bit is also set, unless the channel is marked for auto-initialization.

All programming goes through a single write strobe with a 3-bit operation code and an 8-bit data byte:

| Code | Operation | Data fields |
|------|-----------|-------------|
| 0 | Control | bit0 rotating priority, bit1 controller disable, bit2 request pins active low, bit3 acknowledge pins active high |
| 1 | Single mask | bits 1:0 channel, bit2 set (1) or clear (0) |
| 2 | Write all masks | bits 3:0 loaded into the mask |
| 3 | Clear all masks | none |
| 4 | Software request | bits 1:0 channel, bit2 set (1) or reset (0) |
| 5 | Master clear | none |
| 6 | Auto-init select | bits 1:0 channel, bit2 auto-init on |

The controller state machine has three states:
- `ST_IDLE`: no hold request. The machine goes to `ST_HOLD` when the controller is enabled and any request is pending, and it latches the winner on that move.
- `ST_HOLD`: hold request high. The machine goes to `ST_SERVE` when hold acknowledge is high.
- `ST_SERVE`: hold request high and the winner's acknowledge active. The machine goes back to `ST_IDLE` on end of service.

A master clear sends every state to `ST_IDLE`.

Top module: `dma_req_arbiter`

## Requirements
- R1: With control bit0 = 0, the pending channel with the lowest index wins.
- R2: With control bit0 = 1, the search starts at the channel after the one last served and wraps. After reset or master clear, the last-served channel is 3, so channel 0 is searched first.
- R3: Control bit2 = 1 senses request pins active low, and 0 senses them active high. Control bit3 = 1 drives acknowledge pins active high, and 0 drives them active low.
- R4: Reset and master clear (code 5) set all four mask bits and clear the software requests and the control register. Hold request drops and the acknowledge pins go inactive.
- R5: Code 1 sets or clears the mask bit of one channel (bits 1:0 channel, bit2 set). Code 2 loads bits 3:0 into the mask. Code 3 clears every mask bit. A masked pin request is ignored.
- R6: Code 4 sets or resets one software request bit (bits 1:0 channel, bit2 set). A software request is pending even when the channel's mask bit is set.
- R7: End of service with the terminal flag high clears the served channel's software request. It also sets that channel's mask bit, unless code 6 has enabled auto-init for the channel (bits 1:0 channel, bit2 on).
- R8: The `req_status` bits show, in the same cycle and without a register, which channels are pending. A channel is pending if its sensed pin request is unmasked or its software request is set.
- R9: While control bit1 = 1, no new decision is made and hold request stays low.
- R10: Hold request rises one clock after a decision in idle and stays high until end of service. Exactly one acknowledge goes active, one clock after hold acknowledge is seen high.
- R11: The granted channel stays fixed for the whole service, whatever the requests do meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Programming write strobe |
| cfg_op | input | 3 | Operation code |
| cfg_data | input | 8 | Operation data byte |
| dreq_pin | input | 4 | External request pins |
| hlda | input | 1 | Hold acknowledge from host |
| svc_end | input | 1 | End-of-service pulse from transfer engine |
| svc_term | input | 1 | Service ended by terminal count or end-of-process |
| hrq | output | 1 | Hold request to host |
| dack_pin | output | 4 | Channel acknowledge pins |
| grant_vld | output | 1 | A channel is being served |
| grant_ch | output | 2 | Channel being served |
| req_status | output | 4 | Live pending-request flags |

## Verification
The hardest case to reach from the ports is a rotating-priority decision that follows a terminal-count end, when the served channel's mask may or may not be set again depending on its auto-init bit. The stimulus gets there by programming masks, software requests, auto-init bits, polarities and the priority mode at random while the controller is disabled. It then enables the controller and walks the full hold, acknowledge and end-of-service handshake with a random terminal flag. A reference model in the bench carries the mask, request and last-served state forward from one service to the next. During each service the request pins are scrambled to show that the latched grant does not move.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [2:0] {
        OP_CTRL     = 3'd0,
        OP_MASK_ONE = 3'd1,
        OP_MASK_ALL = 3'd2,
        OP_MASK_CLR = 3'd3,
        OP_SWREQ    = 3'd4,
        OP_MCLR     = 3'd5,
        OP_AUTOINIT = 3'd6,
        OP_NOP      = 3'd7
    } cfg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_SERVE = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic dack_hi;
        logic dreq_lo;
        logic halt;
        logic rotate;
    } ctrl_t;

endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_op,
    input  logic [7:0]     cfg_data,
    input  logic           term_v,
    input  logic [CW-1:0]  term_ch,
    output ctrl_t          ctrl,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] swreq,
    output logic           mclr
);

    logic [NCH-1:0] autoinit;
    cfg_op_e        op;
    logic [CW-1:0]  sel_ch;
    logic           sel_bit;

    always_comb begin
        op      = cfg_op_e'(cfg_op);
        sel_ch  = cfg_data[CW-1:0];
        sel_bit = cfg_data[CW];
        mclr    = cfg_wr && (op == OP_MCLR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            mask     <= '1;
            swreq    <= '0;
            autoinit <= '0;
        end else begin
            if (term_v) begin
                swreq[term_ch] <= 1'b0;
                if (!autoinit[term_ch])
                    mask[term_ch] <= 1'b1;
            end
            if (cfg_wr) begin
                unique case (op)
                    OP_CTRL:     ctrl <= ctrl_t'(cfg_data[3:0]);
                    OP_MASK_ONE: mask[sel_ch] <= sel_bit;
                    OP_MASK_ALL: mask <= cfg_data[NCH-1:0];
                    OP_MASK_CLR: mask <= '0;
                    OP_SWREQ:    swreq[sel_ch] <= sel_bit;
                    OP_MCLR: begin
                        ctrl  <= '0;
                        mask  <= '1;
                        swreq <= '0;
                    end
                    OP_AUTOINIT: autoinit[sel_ch] <= sel_bit;
                    default: ;
                endcase
            end
        end
    end

    AST_TERM_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (term_v && !cfg_wr) |=> !swreq[$past(term_ch)]); // R7
    AST_TERM_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (term_v && !cfg_wr && !autoinit[term_ch]) |=> mask[$past(term_ch)]); // R7
    AST_MCLR_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (mask == '1 && swreq == '0)); // R4

endmodule

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic           rotate,
    input  logic [CW-1:0]  last,
    output logic           any,
    output logic [CW-1:0]  win
);

    // NCH is a power of two so the index wraps in CW bits.
    logic [CW-1:0] base;
    logic [CW-1:0] idx;
    logic          found;

    always_comb begin
        base  = rotate ? CW'(last + 1'b1) : '0;
        any   = |pend;
        win   = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NCH; i++) begin
            idx = CW'(base + CW'(i));
            if (!found && pend[idx]) begin
                win   = idx;
                found = 1'b1;
            end
        end
    end

    AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> pend[win]); // R1
    AST_FIXED_ZERO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!rotate && pend[0]) |-> (win == '0)); // R1
    AST_ROT_NEXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rotate && pend[CW'(last + 1'b1)]) |-> (win == CW'(last + 1'b1))); // R2

endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mclr,
    input  logic          enable,
    input  logic          any,
    input  logic [CW-1:0] win,
    input  logic          hlda,
    input  logic          svc_end,
    output logic          hrq,
    output logic          serving,
    output logic [CW-1:0] grant,
    output logic [CW-1:0] last
);

    arb_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (mclr) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (enable && any) nxt = ST_HOLD;
                ST_HOLD:  if (hlda)          nxt = ST_SERVE;
                ST_SERVE: if (svc_end)       nxt = ST_IDLE;
                default:                     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= '0;
            last  <= CW'(NCH - 1);
        end else if (mclr) begin
            last  <= CW'(NCH - 1);
        end else begin
            if (state == ST_IDLE && nxt == ST_HOLD)
                grant <= win;
            if (state == ST_SERVE && svc_end)
                last <= grant;
        end
    end

    always_comb begin
        hrq     = (state != ST_IDLE);
        serving = (state == ST_SERVE);
    end

    AST_ACK_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SERVE) |-> $past(hlda)); // R10
    AST_SERVE_UNTIL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && !svc_end && !mclr) |=> (state == ST_SERVE)); // R10
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERVE && $past(state == ST_SERVE)) |-> $stable(grant)); // R11
    AST_HALT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [2:0]     cfg_op,
    input  logic [7:0]     cfg_data,
    input  logic [NCH-1:0] dreq_pin,
    input  logic           hlda,
    input  logic           svc_end,
    input  logic           svc_term,
    output logic           hrq,
    output logic [NCH-1:0] dack_pin,
    output logic           grant_vld,
    output logic [CW-1:0]  grant_ch,
    output logic [NCH-1:0] req_status
);

    ctrl_t          ctrl;
    logic [NCH-1:0] mask, swreq, dreq_act, pend;
    logic           mclr, any, serving, term_v;
    logic [CW-1:0]  win, grant, last;

    always_comb begin
        dreq_act = dreq_pin ^ {NCH{ctrl.dreq_lo}};
        pend     = (dreq_act & ~mask) | swreq;
        term_v   = serving && svc_end && svc_term;
    end

    dma_arb_regs #(.NCH(NCH), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
        .cfg_data(cfg_data), .term_v(term_v), .term_ch(grant),
        .ctrl(ctrl), .mask(mask), .swreq(swreq), .mclr(mclr)
    );

    dma_arb_prio #(.NCH(NCH), .CW(CW)) u_prio (
        .clk(clk), .rst_n(rst_n), .pend(pend), .rotate(ctrl.rotate),
        .last(last), .any(any), .win(win)
    );

    dma_arb_fsm #(.NCH(NCH), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .enable(!ctrl.halt),
        .any(any), .win(win), .hlda(hlda), .svc_end(svc_end),
        .hrq(hrq), .serving(serving), .grant(grant), .last(last)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_dack
        assign dack_pin[g] = ~((serving && grant == CW'(g)) ^ ctrl.dack_hi);
    end

    assign grant_vld  = serving;
    assign grant_ch   = grant;
    assign req_status = pend;

    AST_ONE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_pin ^ {NCH{!ctrl.dack_hi}})); // R10
    AST_ACK_NEEDS_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> hrq); // R10

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
    import dma_arb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_op = 3'd7;
    logic [7:0] cfg_data = 8'd0;
    logic [3:0] dreq_pin = 4'd0;
    logic       hlda = 1'b0, svc_end = 1'b0, svc_term = 1'b0;
    logic       hrq, grant_vld;
    logic [3:0] dack_pin, req_status;
    logic [1:0] grant_ch;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    logic [3:0] m_mask = 4'hF, m_sw = 4'h0, m_auto = 4'h0, m_ctrl = 4'h0;
    logic [1:0] m_last = 2'd3;

    always #2.5 clk = ~clk;

    dma_req_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
        .cfg_data(cfg_data), .dreq_pin(dreq_pin), .hlda(hlda),
        .svc_end(svc_end), .svc_term(svc_term), .hrq(hrq),
        .dack_pin(dack_pin), .grant_vld(grant_vld), .grant_ch(grant_ch),
        .req_status(req_status)
    );

    function automatic logic [3:0] exp_pend();
        return ((dreq_pin ^ {4{m_ctrl[2]}}) & ~m_mask) | m_sw;
    endfunction

    function automatic logic [1:0] exp_win(input logic [3:0] p);
        logic [1:0] base = m_ctrl[0] ? 2'(m_last + 2'd1) : 2'd0;
        for (int i = 0; i < 4; i++) begin
            logic [1:0] k = 2'(base + 2'(i));
            if (p[k]) return k;
        end
        return 2'd0;
    endfunction

    function automatic logic [3:0] exp_dack(input logic [1:0] w, input bit on);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = ~((on && w == 2'(i)) ^ m_ctrl[3]);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic model_cfg(input logic [2:0] op, input logic [7:0] d);
        case (op)
            3'd0: m_ctrl = d[3:0];
            3'd1: m_mask[d[1:0]] = d[2];
            3'd2: m_mask = d[3:0];
            3'd3: m_mask = 4'h0;
            3'd4: m_sw[d[1:0]] = d[2];
            3'd5: begin m_mask = 4'hF; m_sw = 0; m_ctrl = 0; m_last = 2'd3; end
            3'd6: m_auto[d[1:0]] = d[2];
            default: ;
        endcase
    endtask

    task automatic cfg(input logic [2:0] op, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_op = op; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_op = 3'd7;
        model_cfg(op, d);
    endtask

    // run one service once the controller is enabled; returns at idle, halted
    task automatic serve(input string tag, input bit term);
        logic [1:0] w = exp_win(exp_pend());
        @(negedge clk);
        chk({tag, " R10 hrq"}, hrq, 1);
        chk({tag, " R10 no ack before hlda"}, dack_pin, exp_dack(w, 0));
        hlda = 1'b1;
        @(negedge clk);
        chk({tag, " R1/R2 grant"}, grant_ch, w);
        chk({tag, " R10 R3 dack"}, dack_pin, exp_dack(w, 1));
        dreq_pin = 4'($urandom);
        @(negedge clk);
        chk({tag, " R11 grant held"}, {grant_vld, dack_pin}, {1'b1, exp_dack(w, 1)});
        svc_end = 1'b1; svc_term = term;
        cfg_wr = 1'b1; cfg_op = 3'd0; cfg_data = {4'd0, m_ctrl | 4'b0010};
        @(negedge clk);
        svc_end = 1'b0; svc_term = 1'b0; cfg_wr = 1'b0; cfg_op = 3'd7; hlda = 1'b0;
        model_cfg(3'd0, {4'd0, m_ctrl | 4'b0010});
        m_last = w;
        if (term) begin
            m_sw[w] = 1'b0;
            if (!m_auto[w]) m_mask[w] = 1'b1;
        end
        chk({tag, " R10 hrq drops"}, hrq, 0);
        chk({tag, " R7 R8 status"}, req_status, exp_pend());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D3A));
        dreq_pin = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset status masked", req_status, 4'h0);
        chk("R4 reset hrq", hrq, 0);
        chk("R4 reset dack", dack_pin, 4'hF);

        // software request bypasses mask while halted
        cfg(3'd0, 8'h02);
        cfg(3'd4, 8'h06);
        chk("R6 sw req through mask", req_status, 4'h4);
        repeat (3) @(negedge clk);
        chk("R9 halted no hrq", hrq, 0);

        // single mask and fixed priority
        cfg(3'd1, 8'h03);
        chk("R5 single clear ch3", req_status, 4'hC);
        cfg(3'd1, 8'h01);
        chk("R5 single clear ch1", req_status, 4'hE);
        cfg(3'd0, 8'h00);
        serve("fixed", 1'b1);
        chk("R1 lowest wins", m_last, 2'd1);

        // active-low requests, active-high acks, rotating
        dreq_pin = 4'h0;
        cfg(3'd3, 8'h00);
        cfg(3'd0, 8'h0F);
        chk("R3 low sense", req_status, 4'hF);
        cfg(3'd2, 8'h05);
        chk("R5 write all", req_status, 4'hA | m_sw);
        cfg(3'd0, 8'h0D);
        serve("rotate", 1'b0);

        // master clear
        cfg(3'd4, 8'h05);
        cfg(3'd5, 8'h00);
        chk("R4 mclr status", req_status, 4'h0);
        chk("R4 mclr dack", dack_pin, 4'hF);

        for (int it = 0; it < 80; it++) begin
            cfg(3'd0, {4'd0, 4'($urandom) | 4'b0010});
            dreq_pin = 4'($urandom);
            for (int k = 0; k < 1 + $urandom % 4; k++) begin
                logic [2:0] op;
                logic [7:0] d = 8'($urandom);
                case ($urandom % 6)
                    0: op = 3'd1; 1: op = 3'd2; 2: op = 3'd3;
                    3: op = 3'd4; 4: op = 3'd6;
                    default: begin op = 3'd0; d[1] = 1'b1; end
                endcase
                cfg(op, d);
            end
            chk("R8 R5 R6 R3 live status", req_status, exp_pend());
            if ($urandom % 8 == 0) begin
                repeat (2) @(negedge clk);
                chk("R9 halted", hrq, 0);
            end else begin
                cfg(3'd0, {4'd0, m_ctrl & 4'b1101});
                chk("R10 idle before decision", hrq, 0);
                if (exp_pend() != 0) begin
                    serve("random", 1'($urandom));
                end else begin
                    @(negedge clk);
                    chk("R10 no request no hrq", hrq, 0);
                    cfg(3'd0, {4'd0, m_ctrl | 4'b0010});
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule